// File: doc/BRIEF.md
# Line doubling scan converter

This block turns a color video stream at the television line rate into a stream that a VGA-class monitor accepts. It does this by showing every source line twice. Source pixels arrive on a write port at the source pixel rate and are stored in one of two on-chip line stores. A line-start strobe marks the beginning of each source line. During the next source line the filled store is read out twice at the full clock rate, while the other store takes in new pixels. The output therefore runs at twice the horizontal frequency, for example 31.5 kHz from a 15.75 kHz source. Low and medium color resolution share this output timing.

Software also watches the sync and display-enable indications, and on the output those come twice per source line. So the block produces a second pair of indications, a horizontal sync and a display enable, at the original line rate. The block counts source lines into frames. A 60 Hz selection uses the shortest frame. For 50 Hz sources a stretch option shortens the frame to the 56 Hz length by dropping blank lines. The number of visible lines is the same in every mode.

Top module: `scan_doubler`

## Requirements
- R1: While reset is held and directly after it, every output is low: the pixel output, both display enables and all three syncs.
- R2: Take the rising edge that samples `line_start` as edge 0. The output position p (from 0 to 2*HALF_TOTAL-1) appears on the outputs after edge p+2. Position p lies in the first output line when p < HALF_TOTAL and in the second otherwise, at column k = p mod HALF_TOTAL. After position 2*HALF_TOTAL-1, `out_de`, `out_hsync`, `emu_hsync` and `emu_de` stay low until the next `line_start`.
- R3: When `out_de` is high at column k, `pix_out` in both output lines equals the k-th pixel accepted during the previous source line. Pixels accepted during the current source line never show up in the current line's output.
- R4: A pixel is accepted when `pix_valid` is high and `line_start` is low. Accepted pixels fill the columns 0 up to ACTIVE_W-1 in order. A pixel offered together with `line_start` is dropped, and so is any pixel offered after ACTIVE_W have been accepted in the line.
- R5: `out_hsync` is high at columns HS_START to HS_START+HS_LEN-1 of each output line, so there are two pulses per source line. It is never high together with `out_de`.
- R6: `emu_hsync` is high at the same columns as `out_hsync`, but only in the first output line of each pair.
- R7: `emu_de` is high at positions p < 2*ACTIVE_W of the line pair, but only while the current source line number is below V_ACTIVE.
- R8: `out_de` is high at columns k < ACTIVE_W, but only while the current source line number lies in the range 1 to V_ACTIVE, which is the output of source lines 0 to V_ACTIVE-1. While `out_de` is low, `pix_out` is zero.
- R9: Each `line_start` advances the source line number, and the number wraps to 0 after the last line of the frame. The first `line_start` after reset gives line 0. The frame length is VT_60 lines when `rate_60` is 1, VT_56 lines when `rate_60` is 0 and `stretch_56` is 1, and VT_50 lines otherwise. `out_vsync` is high on the last VS_LEN lines of the frame.
- R10: While `rate_60` is 1, `stretch_56` has no effect on the frame length or on `out_vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock (twice the source pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe at the start of each source line |
| pix_valid | input | 1 | Source pixel strobe |
| pix_in | input | PIX_W | Source pixel value |
| rate_60 | input | 1 | 1: 60 Hz frame length |
| stretch_56 | input | 1 | 1: shorten the 50 Hz frame to the 56 Hz length |
| pix_out | output | PIX_W | Doubled-rate pixel, zero outside the active area |
| out_de | output | 1 | Doubled-rate display enable |
| out_hsync | output | 1 | Doubled-rate horizontal sync |
| out_vsync | output | 1 | Vertical sync |
| emu_hsync | output | 1 | Horizontal sync at the original line rate |
| emu_de | output | 1 | Display enable at the original line rate |

## Verification
The store that is filling with a new line and the store that is being replayed are in use in the same cycle. On top of that, the role swap at `line_start` can coincide with an offered pixel. The bench raises `pix_valid` with a marker value in the very cycle of every `line_start`, and gives every line a different pixel pattern. If the store selection were wrong, the current line's pixels or the marker would appear in the replay. If the write address were not cleared properly, every stored pixel would shift by one column. A compact configuration is swept position by position over several frames in each of the three frame-length settings, and each output is compared with values the bench computes from the line number and the column.

// File: rtl/sd_pkg.sv
package sd_pkg;

  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
    logic ehs;
    logic ede;
  } sd_ctl_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sd_line_ram.sv
module sd_line_ram #(
  parameter int DW    = 4,
  parameter int DEPTH = 640,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sd_htimer.sv
module sd_htimer #(
  parameter int HALF_TOTAL = 800,
  parameter int ACTIVE_W   = 640,
  parameter int HS_START   = 672,
  parameter int HS_LEN     = 96,
  localparam int HW        = $clog2(HALF_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  output logic [HW-1:0] hcnt,
  output logic          h_act,
  output logic          h_sync,
  output logic          e_sync,
  output logic          e_act
);

  logic second;
  logic run;
  int   pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      second <= 1'b0;
      run    <= 1'b0;
    end else if (line_start) begin
      hcnt   <= '0;
      second <= 1'b0;
      run    <= 1'b1;
    end else if (run) begin
      if (int'(hcnt) == HALF_TOTAL - 1) begin
        hcnt <= '0;
        if (second) run <= 1'b0;
        second <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_comb begin
    pos    = (second ? HALF_TOTAL : 0) + int'(hcnt);
    h_act  = run && (int'(hcnt) < ACTIVE_W);
    h_sync = run && (int'(hcnt) >= HS_START) && (int'(hcnt) < HS_START + HS_LEN);
    e_sync = h_sync && !second;
    e_act  = run && (pos < 2 * ACTIVE_W);
  end

  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(line_start));

  // R5
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(hcnt) < HALF_TOTAL);

endmodule

// File: rtl/sd_vtimer.sv
module sd_vtimer
  import sd_pkg::*;
#(
  parameter int V_ACTIVE = 200,
  parameter int VT_50    = 313,
  parameter int VT_56    = 280,
  parameter int VT_60    = 263,
  parameter int VS_LEN   = 3,
  localparam int VW      = $clog2(max3(VT_50, VT_56, VT_60))
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic rate_60,
  input  logic stretch_56,
  output logic v_out_act,
  output logic v_src_act,
  output logic vsync
);

  logic [VW-1:0] vline;
  int            vtot;

  always_comb begin
    if (rate_60)         vtot = VT_60;
    else if (stretch_56) vtot = VT_56;
    else                 vtot = VT_50;
  end

  // all-ones before the first line, so the first strobe wraps to 0
  always_ff @(posedge clk) begin
    if (rst)             vline <= '1;
    else if (line_start) vline <= (int'(vline) >= vtot - 1) ? '0 : vline + 1'b1;
  end

  always_comb begin
    v_out_act = (int'(vline) >= 1) && (int'(vline) <= V_ACTIVE);
    v_src_act = int'(vline) < V_ACTIVE;
    vsync     = (int'(vline) >= vtot - VS_LEN) && (int'(vline) < vtot);
  end

  // R9
  vline_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> int'(vline) < $past(vtot));

endmodule

// File: rtl/scan_doubler.sv
module scan_doubler
  import sd_pkg::*;
#(
  parameter int PIX_W      = 4,
  parameter int ACTIVE_W   = 640,
  parameter int HALF_TOTAL = 800,
  parameter int HS_START   = 672,
  parameter int HS_LEN     = 96,
  parameter int V_ACTIVE   = 200,
  parameter int VT_50      = 313,
  parameter int VT_56      = 280,
  parameter int VT_60      = 263,
  parameter int VS_LEN     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             rate_60,
  input  logic             stretch_56,
  output logic [PIX_W-1:0] pix_out,
  output logic             out_de,
  output logic             out_hsync,
  output logic             out_vsync,
  output logic             emu_hsync,
  output logic             emu_de
);

  localparam int AW = $clog2(ACTIVE_W);
  localparam int HW = $clog2(HALF_TOTAL);

  logic [HW-1:0]    hcnt;
  logic             h_act, h_sync, e_sync, e_act;
  logic             v_out_act, v_src_act, vsync;
  logic             wsel;
  logic [AW:0]      waddr;
  logic             wr_ok;
  logic [AW-1:0]    raddr;
  logic [PIX_W-1:0] rq [2];
  sd_ctl_t          ctl_a, ctl_b;
  logic             rsel_b;

  sd_htimer #(
    .HALF_TOTAL(HALF_TOTAL), .ACTIVE_W(ACTIVE_W),
    .HS_START(HS_START), .HS_LEN(HS_LEN)
  ) u_ht (
    .clk(clk), .rst(rst), .line_start(line_start), .hcnt(hcnt),
    .h_act(h_act), .h_sync(h_sync), .e_sync(e_sync), .e_act(e_act)
  );

  sd_vtimer #(
    .V_ACTIVE(V_ACTIVE), .VT_50(VT_50), .VT_56(VT_56),
    .VT_60(VT_60), .VS_LEN(VS_LEN)
  ) u_vt (
    .clk(clk), .rst(rst), .line_start(line_start), .rate_60(rate_60),
    .stretch_56(stretch_56), .v_out_act(v_out_act), .v_src_act(v_src_act),
    .vsync(vsync)
  );

  // write side: the store roles swap on every line strobe
  assign wr_ok = pix_valid && !line_start && (int'(waddr) < ACTIVE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel  <= 1'b0;
      waddr <= '0;
    end else if (line_start) begin
      wsel  <= ~wsel;
      waddr <= '0;
    end else if (wr_ok) begin
      waddr <= waddr + 1'b1;
    end
  end

  assign raddr = h_act ? hcnt[AW-1:0] : '0;

  for (genvar i = 0; i < 2; i++) begin : g_buf
    sd_line_ram #(.DW(PIX_W), .DEPTH(ACTIVE_W)) u_ram (
      .clk(clk),
      .we(wr_ok && (wsel == 1'(i))),
      .waddr(waddr[AW-1:0]),
      .wdata(pix_in),
      .raddr(raddr),
      .rdata(rq[i])
    );
  end

  always_comb begin
    ctl_a.de  = h_act && v_out_act;
    ctl_a.hs  = h_sync;
    ctl_a.vs  = vsync;
    ctl_a.ehs = e_sync;
    ctl_a.ede = e_act && v_src_act;
  end

  // stage b runs alongside the store read, stage c registers the outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_b     <= '0;
      rsel_b    <= 1'b0;
      pix_out   <= '0;
      out_de    <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      emu_hsync <= 1'b0;
      emu_de    <= 1'b0;
    end else begin
      ctl_b     <= ctl_a;
      rsel_b    <= ~wsel;
      pix_out   <= ctl_b.de ? rq[rsel_b] : '0;
      out_de    <= ctl_b.de;
      out_hsync <= ctl_b.hs;
      out_vsync <= ctl_b.vs;
      emu_hsync <= ctl_b.ehs;
      emu_de    <= ctl_b.ede;
    end
  end

  // R3
  buf_swap_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (wsel != $past(wsel)) && (waddr == '0));

  // R4
  waddr_limit_chk: assert property (@(posedge clk) disable iff (rst)
    int'(waddr) <= ACTIVE_W);

  // R5
  sync_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_de && out_hsync));

  // R6
  emu_sync_chk: assert property (@(posedge clk) disable iff (rst)
    emu_hsync |-> out_hsync);

  // R8
  pix_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !out_de |-> (pix_out == '0));

endmodule

// File: tb/sim_scan_doubler.sv
module sim_scan_doubler;

  localparam int PW  = 4;
  localparam int A   = 8;
  localparam int HT  = 14;
  localparam int HS0 = 10;
  localparam int HSL = 2;
  localparam int VA  = 4;
  localparam int V50 = 9;
  localparam int V56 = 7;
  localparam int V60 = 6;
  localparam int VSL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic pix_valid = 1'b0;
  logic [PW-1:0] pix_in = '0;
  logic rate_60 = 1'b0;
  logic stretch_56 = 1'b0;
  logic [PW-1:0] pix_out;
  logic out_de, out_hsync, out_vsync, emu_hsync, emu_de;

  int vectors = 0;
  int errors  = 0;
  int vl = -1;
  int cur [A];
  int prev [A];
  int ln = 0;

  always #2 clk = ~clk;

  scan_doubler #(
    .PIX_W(PW), .ACTIVE_W(A), .HALF_TOTAL(HT), .HS_START(HS0), .HS_LEN(HSL),
    .V_ACTIVE(VA), .VT_50(V50), .VT_56(V56), .VT_60(V60), .VS_LEN(VSL)
  ) u0 (
    .clk(clk), .rst(rst), .line_start(line_start), .pix_valid(pix_valid),
    .pix_in(pix_in), .rate_60(rate_60), .stretch_56(stretch_56),
    .pix_out(pix_out), .out_de(out_de), .out_hsync(out_hsync),
    .out_vsync(out_vsync), .emu_hsync(emu_hsync), .emu_de(emu_de)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s line %0d: actual %0d expected %0d", req, what, vl, act, exp);
    end
  endtask

  function automatic int pat(input int l, input int i);
    return (l * 3 + i * 5 + 1) % 15;
  endfunction

  function automatic int vtot();
    if (rate_60) return V60;
    if (stretch_56) return V56;
    return V50;
  endfunction

  task automatic do_line();
    int widx;
    int p, h, k, de, hs;
    string vreq;
    widx = 0;
    @(negedge clk);
    line_start = 1'b1;
    pix_valid  = 1'b1;   // R4: offered together with the strobe, must be dropped
    pix_in     = 4'hF;
    for (int i = 0; i < A; i++) prev[i] = cur[i];
    vl = (vl < 0 || vl >= vtot() - 1) ? 0 : vl + 1;
    ln++;
    for (int j = 0; j < 2 * HT + 2; j++) begin
      @(posedge clk);
      @(negedge clk);
      line_start = 1'b0;
      if (j < 2) begin
        // R2: the previous pair has ended, nothing active
        chk("R2", "idle out_de", int'(out_de), 0);
        chk("R2", "idle out_hsync", int'(out_hsync), 0);
        chk("R2", "idle emu_de", int'(emu_de), 0);
      end else begin
        p  = j - 2;
        h  = p / HT;
        k  = p % HT;
        de = (k < A && vl >= 1 && vl <= VA) ? 1 : 0;
        hs = (k >= HS0 && k < HS0 + HSL) ? 1 : 0;
        chk("R8", "out_de", int'(out_de), de);
        chk("R3", "pix_out", int'(pix_out), de ? prev[k] : 0);
        chk("R5", "out_hsync", int'(out_hsync), hs);
        chk("R6", "emu_hsync", int'(emu_hsync), (hs && h == 0) ? 1 : 0);
        chk("R7", "emu_de", int'(emu_de), (p < 2 * A && vl < VA) ? 1 : 0);
        vreq = (rate_60 && stretch_56) ? "R10" : "R9";
        chk(vreq, "out_vsync", int'(out_vsync),
            (vl >= vtot() - VSL && vl < vtot()) ? 1 : 0);
      end
      // source side: one pixel every other cycle, two beyond the line length
      if (j % 2 == 0 && widx < A + 2) begin
        pix_valid = 1'b1;
        pix_in    = PW'(pat(ln, widx));
        if (widx < A) cur[widx] = pat(ln, widx);  // R4: extras are dropped
        widx++;
      end else begin
        pix_valid = 1'b0;
        pix_in    = 4'hF;
      end
    end
    pix_valid = 1'b0;
  endtask

  task automatic run_mode(input logic r60, input logic s56, input int frames);
    @(negedge clk);
    rate_60    = r60;
    stretch_56 = s56;
    for (int f = 0; f < frames * vtot(); f++) do_line();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < A; i++) cur[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "pix_out", int'(pix_out), 0);
    chk("R1", "out_de", int'(out_de), 0);
    chk("R1", "out_hsync", int'(out_hsync), 0);
    chk("R1", "out_vsync", int'(out_vsync), 0);
    chk("R1", "emu_hsync", int'(emu_hsync), 0);
    chk("R1", "emu_de", int'(emu_de), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_vsync after reset", int'(out_vsync), 0);
    chk("R1", "out_de after reset", int'(out_de), 0);
    run_mode(1'b0, 1'b0, 2);   // R9: 50 Hz frame length
    run_mode(1'b0, 1'b1, 2);   // R9: stretched frame length
    run_mode(1'b1, 1'b0, 2);   // R9: 60 Hz frame length
    run_mode(1'b1, 1'b1, 2);   // R10: stretch has no effect at 60 Hz
    run_mode(1'b0, 1'b0, 1);
    finish_run();
  end

endmodule